// File: doc/BRIEF.md
# Pipelined Instruction Fetch Controller

This block is the control heart of the first stage of a pipelined processor. Every cycle it weighs the feedback that later stages send back: redirects from commit and from decode, a busy flag while the reorder buffer is still unwinding, and four stall lines. From these it picks its next stage status. When it is free to fetch, it builds a group of up to `W` consecutive instructions from one buffered cache line and hands the group to decode as a registered packet. Each slot of the packet carries its PC, its predicted next PC, its instruction word and a sequence number.

A group is cut short at the end of the cache line, at the width limit, or right after a slot that the next-PC predictor marks as taken. The predictor is an external combinational lookup that the block drives with one PC per slot. When a squash carries a mispredict, the block also emits training data for that predictor. Instruction memory is reached through a single-outstanding line request port. A squash cancels a pending request. A faulting response raises a flag with the faulting PC and parks the stage in Blocked.

Top module: `fetch_ctrl`

## Requirements
- R1: Under reset the status reads Running (code 0), the fetch PC equals `RESET_PC`, no packet, request or cancel is emitted, and the first fetched instruction gets sequence number 0.
- R2: A commit squash wins over every other input. On the next edge the fetch PC becomes the commit redirect PC, the status becomes Squashing (code 2), and no packet is produced.
- R3: During a cycle with a commit squash and commit mispredict, `train_valid` is high and the training port carries the commit branch PC, its taken outcome and the commit redirect PC as target. This holds even when decode also squashes.
- R4: While the reorder-buffer-busy input is high and there is no commit squash, the status is Squashing and no packet is produced.
- R5: A decode squash redirects (fetch PC ← decode redirect, status Squashing) only when there is no commit squash, the ROB is not busy, and the status is not Squashing. Otherwise the fetch PC is unchanged. A decode mispredict in a cycle with no commit squash and no ROB busy drives training with the decode branch PC, outcome and redirect PC.
- R6: With no redirect taken, any of the four stall inputs high sends the status to Blocked (code 1), whatever the status was.
- R7: Leaving Blocked (no stall) or Squashing (no squash, not busy) takes one idle cycle: the status becomes Running and no packet is emitted on that edge.
- R8: When fetch is allowed and the fetch PC's line is not buffered, the block pulses `mem_req` with the line-aligned address and enters IcacheMissStall (code 3). A good response moves it to IcacheMissComplete (code 4). The next edge emits a group from that line and returns to Running.
- R9: A redirect while a line request is outstanding pulses `mem_cancel` together with the move to Squashing. The cancelled response is never used, and the previously buffered line stays usable.
- R10: A group holds consecutive words and stops at whichever comes first: `W` slots, the last word of the 64-byte line, or a slot predicted taken (that slot is included). `out_count` gives the number of valid slots.
- R11: Slot k's predicted next PC is the predictor target if that slot is predicted taken, else its PC plus 4. Sequence numbers increase by one per instruction across groups. After a group the fetch PC equals the last slot's predicted next PC. The instruction word in a slot is the line word at that PC's offset.
- R12: A response flagged as a fault pulses `out_fault` with `out_fault_pc` set to the PC that missed, emits no group and puts the stage in Blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_squash | input | 1 | Squash from commit |
| c_redirect | input | AW | Commit redirect PC |
| c_mispred | input | 1 | Commit squash is a branch mispredict |
| c_bpc | input | AW | PC of the mispredicted branch (commit) |
| c_btaken | input | 1 | Actual outcome of that branch (commit) |
| rob_busy | input | 1 | Reorder buffer still squashing |
| d_squash | input | 1 | Squash from decode |
| d_redirect | input | AW | Decode redirect PC |
| d_mispred | input | 1 | Decode squash is a branch mispredict |
| d_bpc | input | AW | PC of the mispredicted branch (decode) |
| d_btaken | input | 1 | Actual outcome of that branch (decode) |
| stall_dec | input | 1 | Stall from decode |
| stall_ren | input | 1 | Stall from rename |
| stall_exe | input | 1 | Stall from execute |
| stall_cmt | input | 1 | Stall from commit |
| mem_req | output | 1 | Line read request pulse |
| mem_addr | output | AW | Line-aligned request address |
| mem_cancel | output | 1 | Cancel the outstanding request |
| resp_valid | input | 1 | Line response valid |
| resp_fault | input | 1 | Response carries a fault |
| resp_line | input | BLK*8 | Line data, word k at bits [k*IW +: IW] |
| pred_pc | output | W*AW | PC looked up for each slot |
| pred_taken | input | W | Slot predicted taken |
| pred_target | input | W*AW | Predicted target per slot |
| train_valid | output | 1 | Predictor training strobe |
| train_pc | output | AW | Branch PC to train |
| train_taken | output | 1 | Branch outcome to train |
| train_target | output | AW | New target to train |
| out_valid | output | 1 | Group packet valid |
| out_count | output | CW | Valid slots in the packet |
| out_pc | output | W*AW | Slot PCs |
| out_npc | output | W*AW | Slot predicted next PCs |
| out_inst | output | W*IW | Slot instruction words |
| out_seq | output | W*SW | Slot sequence numbers |
| out_fault | output | 1 | Fetch fault pulse |
| out_fault_pc | output | AW | Faulting PC |
| stage_state | output | 3 | Status: 0 Running, 1 Blocked, 2 Squashing, 3 miss stall, 4 miss complete |

## Verification
The assertions assume that the memory side answers only a request that is still outstanding, with at most one `resp_valid` pulse per request and none after a cancel. They also assume that redirect PCs are word-aligned and that the predictor is a pure function of `pred_pc`. The bench's memory model keeps to this: it answers once after a fixed latency, drops its pending answer when it sees `mem_cancel`, and builds each line from the address. All redirect PCs in the bench are multiples of 4, and the bench predictor marks one chosen PC as taken.

// File: rtl/fetch_ctrl.sv
module fetch_ctrl #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int BLK = 64,
  parameter int W = 4,
  parameter int SW = 16,
  parameter int unsigned RESET_PC = 'h100,
  localparam int ISZ = IW / 8,
  localparam int ISB = $clog2(ISZ),
  localparam int OFFB = $clog2(BLK),
  localparam int WPL = BLK / ISZ,
  localparam int CW = $clog2(W + 1),
  localparam int LBITS = BLK * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             c_squash,
  input  logic [AW-1:0]    c_redirect,
  input  logic             c_mispred,
  input  logic [AW-1:0]    c_bpc,
  input  logic             c_btaken,
  input  logic             rob_busy,
  input  logic             d_squash,
  input  logic [AW-1:0]    d_redirect,
  input  logic             d_mispred,
  input  logic [AW-1:0]    d_bpc,
  input  logic             d_btaken,
  input  logic             stall_dec,
  input  logic             stall_ren,
  input  logic             stall_exe,
  input  logic             stall_cmt,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cancel,
  input  logic             resp_valid,
  input  logic             resp_fault,
  input  logic [LBITS-1:0] resp_line,
  output logic [W*AW-1:0]  pred_pc,
  input  logic [W-1:0]     pred_taken,
  input  logic [W*AW-1:0]  pred_target,
  output logic             train_valid,
  output logic [AW-1:0]    train_pc,
  output logic             train_taken,
  output logic [AW-1:0]    train_target,
  output logic             out_valid,
  output logic [CW-1:0]    out_count,
  output logic [W*AW-1:0]  out_pc,
  output logic [W*AW-1:0]  out_npc,
  output logic [W*IW-1:0]  out_inst,
  output logic [W*SW-1:0]  out_seq,
  output logic             out_fault,
  output logic [AW-1:0]    out_fault_pc,
  output logic [2:0]       stage_state
);

  typedef enum logic [2:0] {RUN = 3'd0, BLOCK = 3'd1, SQ = 3'd2, MISS = 3'd3, MDONE = 3'd4} st_t;

  st_t                st;
  logic [AW-1:0]      fpc, miss_pc;
  logic [SW-1:0]      seq;
  logic [LBITS-1:0]   line_q;
  logic [AW-OFFB-1:0] line_tag;
  logic               line_ok, pend;

  logic [AW-1:0] s_pc [W];
  logic [AW-1:0] s_npc [W];
  logic [IW-1:0] s_ins [W];
  logic [W-1:0]  s_ok;
  logic [CW-1:0] cnt;
  logic [AW-1:0] nxt;

  wire any_stall = stall_dec | stall_ren | stall_exe | stall_cmt;
  wire dec_seen  = d_squash & ~c_squash & ~rob_busy;
  wire dec_redir = dec_seen & (st != SQ);
  wire redirect  = c_squash | dec_redir;
  wire got_resp  = pend & resp_valid & ~redirect;
  wire hit       = line_ok & (line_tag == fpc[AW-1:OFFB]);

  assign train_valid  = (c_squash & c_mispred) | (dec_seen & d_mispred);
  assign train_pc     = c_squash ? c_bpc : d_bpc;
  assign train_taken  = c_squash ? c_btaken : d_btaken;
  assign train_target = c_squash ? c_redirect : d_redirect;
  assign stage_state  = st;

  always_comb begin
    logic run;
    run = hit;
    cnt = '0;
    nxt = fpc;
    for (int i = 0; i < W; i++) begin
      s_pc[i]  = fpc + AW'(i * ISZ);
      s_ok[i]  = run && (int'(fpc[OFFB-1:ISB]) + i < WPL);
      run      = s_ok[i] && !pred_taken[i];
      s_npc[i] = pred_taken[i] ? pred_target[i*AW +: AW] : s_pc[i] + AW'(ISZ);
      s_ins[i] = line_q[int'(s_pc[i][OFFB-1:ISB])*IW +: IW];
      if (s_ok[i]) begin
        cnt = cnt + CW'(1);
        nxt = s_npc[i];
      end
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_pred
    assign pred_pc[g*AW +: AW] = s_pc[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RUN;
      fpc <= AW'(RESET_PC);
      miss_pc <= '0;
      seq <= '0;
      line_q <= '0;
      line_tag <= '0;
      line_ok <= 1'b0;
      pend <= 1'b0;
      mem_req <= 1'b0;
      mem_addr <= '0;
      mem_cancel <= 1'b0;
      out_valid <= 1'b0;
      out_count <= '0;
      out_pc <= '0;
      out_npc <= '0;
      out_inst <= '0;
      out_seq <= '0;
      out_fault <= 1'b0;
      out_fault_pc <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_cancel <= 1'b0;
      out_valid <= 1'b0;
      out_fault <= 1'b0;
      if (got_resp) begin
        pend <= 1'b0;
        if (resp_fault) begin
          line_ok <= 1'b0;
          out_fault <= 1'b1;
          out_fault_pc <= miss_pc;
        end else begin
          line_ok <= 1'b1;
          line_q <= resp_line;
          line_tag <= miss_pc[AW-1:OFFB];
        end
      end
      if (redirect) begin
        st <= SQ;
        fpc <= c_squash ? c_redirect : d_redirect;
        pend <= 1'b0;
        mem_cancel <= pend;
      end else if (rob_busy) begin
        st <= SQ;
      end else if (any_stall) begin
        st <= BLOCK;
      end else if (st == BLOCK || st == SQ) begin
        st <= RUN;
      end else if (st == MISS || !hit) begin
        if (got_resp) begin
          st <= resp_fault ? BLOCK : MDONE;
        end else begin
          st <= MISS;
          if (!pend) begin
            pend <= 1'b1;
            mem_req <= 1'b1;
            mem_addr <= {fpc[AW-1:OFFB], OFFB'(0)};
            miss_pc <= fpc;
          end
        end
      end else begin
        st <= RUN;
        out_valid <= 1'b1;
        out_count <= cnt;
        fpc <= nxt;
        seq <= seq + SW'(cnt);
        for (int i = 0; i < W; i++) begin
          out_pc[i*AW +: AW] <= s_pc[i];
          out_npc[i*AW +: AW] <= s_npc[i];
          out_inst[i*IW +: IW] <= s_ins[i];
          out_seq[i*SW +: SW] <= seq + SW'(i);
        end
      end
    end
  end

  // R2
  commit_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_squash |=> (st == SQ) && (fpc == $past(c_redirect)) && !out_valid);

  // R4
  rob_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_busy && !c_squash) |=> (st == SQ) && !out_valid);

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stall && !c_squash && !rob_busy && !(d_squash && st != SQ)) |=> (st == BLOCK) && !out_valid);

  // R7
  unblock_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == BLOCK || st == SQ) && !any_stall && !c_squash && !rob_busy && !d_squash)
      |=> (st == RUN) && !out_valid);

  // R8
  req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (st == MISS) && (mem_addr[OFFB-1:0] == '0));

  // R9
  cancel_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cancel |-> (st == SQ) && !mem_req);

  // R10
  group_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count >= CW'(1)) && (out_count <= CW'(W)));

  // R12
  fault_no_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> !out_valid);

endmodule

// File: tb/fetch_ctrl_test.sv
module fetch_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 32, IW = 32, BLK = 64, W = 4, SW = 16;
  localparam int LBITS = BLK * 8;

  logic clk = 0, rst_n = 0;
  logic c_squash = 0, c_mispred = 0, c_btaken = 0, rob_busy = 0;
  logic [AW-1:0] c_redirect = 0, c_bpc = 0, d_redirect = 0, d_bpc = 0;
  logic d_squash = 0, d_mispred = 0, d_btaken = 0;
  logic stall_dec = 1, stall_ren = 0, stall_exe = 0, stall_cmt = 0;
  logic mem_req, mem_cancel, resp_valid = 0, resp_fault = 0;
  logic [AW-1:0] mem_addr;
  logic [LBITS-1:0] resp_line = 0;
  logic [W*AW-1:0] pred_pc, pred_target, out_pc, out_npc;
  logic [W-1:0] pred_taken;
  logic train_valid, train_taken, out_valid, out_fault;
  logic [AW-1:0] train_pc, train_target, out_fault_pc;
  logic [2:0] out_count, stage_state;
  logic [W*IW-1:0] out_inst;
  logic [W*SW-1:0] out_seq;

  logic [AW-1:0] tk_pc = 32'hFFFF_FFF0, tk_tgt = 0, fault_addr = 32'hFFFF_FF00;
  logic [AW-1:0] m_addr = 0;
  int m_cnt = 0, resp_sent = 0, checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fetch_ctrl uut (.*);

  always_comb
    for (int i = 0; i < W; i++) begin
      pred_taken[i] = (pred_pc[i*AW +: AW] == tk_pc);
      pred_target[i*AW +: AW] = tk_tgt;
    end

  function automatic logic [IW-1:0] word_at(input logic [AW-1:0] a);
    return a ^ 32'hA500_0000;
  endfunction

  always @(negedge clk) begin
    resp_valid <= 0;
    if (mem_cancel) m_cnt = 0;
    else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
      if (m_cnt == 0) begin
        resp_valid <= 1;
        resp_fault <= (m_addr == fault_addr);
        for (int k = 0; k < BLK/4; k++) resp_line[k*IW +: IW] <= word_at(m_addr + AW'(4*k));
        resp_sent++;
      end
    end
    if (mem_req) begin m_addr = mem_addr; m_cnt = 2; end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic chk_slot(input string tag, input int k, input logic [AW-1:0] pc,
                          input logic [AW-1:0] npc, input int sq);
    chk({tag, " pc"}, out_pc[k*AW +: AW], pc);
    chk({tag, " npc"}, out_npc[k*AW +: AW], npc);
    chk({tag, " inst"}, out_inst[k*IW +: IW], word_at(pc));
    chk({tag, " seq"}, out_seq[k*SW +: SW], sq);
  endtask

  task automatic t_reset;
    step;
    chk("R1 state", stage_state, 0);
    chk("R1 pc", uut.fpc, 32'h100);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    rst_n = 1;
    step;
    chk("R6 blocked after reset", stage_state, 1);
  endtask

  task automatic t_miss_group;
    c_squash = 1; c_redirect = 32'h100; stall_dec = 0;
    step;
    chk("R2 state", stage_state, 2);
    chk("R2 no group", out_valid, 0);
    c_squash = 0;
    step;
    chk("R7 squash idle", stage_state, 0);
    chk("R7 no group", out_valid, 0);
    step;
    chk("R8 req", mem_req, 1);
    chk("R8 addr", mem_addr, 32'h100);
    chk("R8 stall state", stage_state, 3);
    for (int k = 0; k < 10 && stage_state != 4; k++) step;
    chk("R8 miss complete", stage_state, 4);
    step;
    chk("R8 group valid", out_valid, 1);
    chk("R10 width count", out_count, 4);
    chk_slot("R1 R11 slot0", 0, 32'h100, 32'h104, 0);
    chk_slot("R11 slot3", 3, 32'h10C, 32'h110, 3);
    chk("R11 next fetch pc", uut.fpc, 32'h110);
    chk("R8 back running", stage_state, 0);
    stall_exe = 1;
    step;
    chk("R6 stall blocks", stage_state, 1);
  endtask

  task automatic t_taken;
    tk_pc = 32'h114; tk_tgt = 32'h188; stall_exe = 0;
    step;
    chk("R7 unblock idle", stage_state, 0);
    chk("R7 unblock no group", out_valid, 0);
    step;
    chk("R10 taken count", out_count, 2);
    chk_slot("R11 taken slot0", 0, 32'h110, 32'h114, 4);
    chk_slot("R11 taken slot1", 1, 32'h114, 32'h188, 5);
    chk("R11 pc follows target", uut.fpc, 32'h188);
    stall_exe = 1; tk_pc = 32'hFFFF_FFF0;
    step;
  endtask

  task automatic t_line_end;
    d_squash = 1; d_redirect = 32'h138; d_mispred = 1; d_bpc = 32'h150; d_btaken = 1;
    #1;
    chk("R5 train valid", train_valid, 1);
    chk("R5 train pc", train_pc, 32'h150);
    chk("R5 train target", train_target, 32'h138);
    chk("R5 train taken", train_taken, 1);
    step;
    chk("R5 decode redirect state", stage_state, 2);
    chk("R5 decode redirect pc", uut.fpc, 32'h138);
    d_squash = 0; d_mispred = 0; stall_exe = 0;
    step;
    step;
    chk("R10 line end count", out_count, 2);
    chk_slot("R10 line end slot1", 1, 32'h13C, 32'h140, 7);
    chk("R11 pc after line", uut.fpc, 32'h140);
    stall_exe = 1;
    step;
  endtask

  task automatic t_priority_cancel;
    int sent;
    c_squash = 1; c_redirect = 32'h200; c_mispred = 1; c_bpc = 32'h1F0; c_btaken = 0;
    d_squash = 1; d_redirect = 32'h300; d_mispred = 1; d_bpc = 32'h2F0;
    #1;
    chk("R3 train valid", train_valid, 1);
    chk("R3 train pc", train_pc, 32'h1F0);
    chk("R3 train target", train_target, 32'h200);
    chk("R3 train taken", train_taken, 0);
    step;
    chk("R2 commit wins pc", uut.fpc, 32'h200);
    c_squash = 0; c_mispred = 0; d_squash = 0; d_mispred = 0; rob_busy = 1; stall_exe = 0;
    step;
    chk("R4 rob busy state", stage_state, 2);
    chk("R4 rob busy no group", out_valid, 0);
    rob_busy = 0; d_squash = 1; d_redirect = 32'h300;
    step;
    chk("R5 ignored while squashing", uut.fpc, 32'h200);
    chk("R7 to running", stage_state, 0);
    d_squash = 0;
    step;
    chk("R8 req 0x200", mem_addr, 32'h200);
    c_squash = 1; c_redirect = 32'h100;
    step;
    chk("R9 cancel", mem_cancel, 1);
    chk("R9 squashing", stage_state, 2);
    sent = resp_sent;
    c_squash = 0; stall_exe = 1;
    repeat (5) step;
    chk("R9 no response", resp_sent, sent);
    stall_exe = 0;
    step;
    step;
    chk("R9 old line kept count", out_count, 4);
    chk_slot("R9 old line slot0", 0, 32'h100, 32'h104, 8);
    stall_exe = 1;
    step;
  endtask

  task automatic t_fault;
    fault_addr = 32'h400; d_squash = 1; d_redirect = 32'h400; stall_exe = 0;
    step;
    chk("R5 redirect to fault pc", stage_state, 2);
    d_squash = 0;
    step;
    step;
    chk("R8 fault req", mem_req, 1);
    for (int k = 0; k < 10 && !out_fault; k++) step;
    chk("R12 fault flag", out_fault, 1);
    chk("R12 fault pc", out_fault_pc, 32'h400);
    chk("R12 blocked", stage_state, 1);
    chk("R12 no group", out_valid, 0);
    stall_exe = 1;
  endtask

  initial begin
    t_reset;
    t_miss_group;
    t_taken;
    t_line_end;
    t_priority_cancel;
    t_fault;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule